// File: doc/BRIEF.md
# Burst Word Address Sequencer for a 32-bit Bus Target

This block supplies a 32-bit bus target with the word address of every data phase in a burst. At the address phase it captures the address. The two lowest address bits are not part of the word address: they carry a code that sets the burst order. After each completed data phase the block moves to the next word address in that order. It tells the target state machine when the transaction has to be cut short with a disconnect.

The block supports two burst orders. In linear order the address rises one word (4 bytes) per phase until the initiator ends the transfer. In cache-line order the burst stays inside one 32-byte line (8 words). For reads it starts at the critical word, runs to the end of the line, and wraps back to the first word of the same line. For writes it does not wrap: it asks for a disconnect once the last word of the line has been transferred. Reserved codes are refused with a disconnect. The raw low bits still reach the bus parity logic unchanged; that logic sits outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: On a cycle with `addr_valid` high, the next cycle shows `word_addr` = `addr_in[31:2]`. The same edge clears `wrapped`, `line_done` and `disc_req`, except that a reserved code sets `disc_req` (see R7).
- R2: Code `addr_in[1:0]` = 2'b00 selects linear order. Each accepted `phase_done` adds 1 to `word_addr` (4 bytes), modulo 2^30, and never raises `disc_req`.
- R3: Code 2'b10 with `is_write` low selects a wrapping read. Each accepted `phase_done` keeps `word_addr[29:3]` fixed and adds 1 to `word_addr[2:0]`, modulo 8.
- R4: `wrapped` goes high the cycle after a wrapping-read phase that completes at line word 7 (`word_addr[2:0]` = 7). It stays high until the next address phase.
- R5: `line_done` goes high the cycle after the eighth completed phase of a wrapping read. Any later `phase_done` raises `disc_req` in the following cycle and leaves `word_addr` unchanged.
- R6: Code 2'b10 with `is_write` high never wraps. The phase that completes at line word 7 raises `disc_req` in the next cycle, and `word_addr` stays at that last word.
- R7: Codes 2'b01 and 2'b11 are reserved. They raise `disc_req` in the cycle after the address phase, and `phase_done` does not change `word_addr`.
- R8: While `disc_req` is high, `phase_done` has no effect on `word_addr`.
- R9: `xfer_end` clears `disc_req` in the next cycle. After it, `phase_done` is ignored until the next address phase.
- R10: While `rst_n` is low, `word_addr` is 0 and `wrapped`, `line_done` and `disc_req` are all low.
- R11: When `addr_valid` and `phase_done` are high in the same cycle, the address load wins and no step is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address phase strobe |
| addr_in | input | 32 | Bus address; bits 1:0 carry the burst order code |
| is_write | input | 1 | Direction of the transaction, high for a write |
| phase_done | input | 1 | A data phase completed this cycle |
| xfer_end | input | 1 | The transaction ended this cycle |
| word_addr | output | 30 | Current word address (byte address bits 31:2) |
| wrapped | output | 1 | A wrapping read has returned to the start of its line |
| line_done | output | 1 | All 8 words of a wrapping read have been transferred |
| disc_req | output | 1 | Disconnect request to the target state machine |

## Verification
The hardest state to reach from the ports is a wrapping read that has already moved all eight words and then receives one more data phase. The bench gets there by choosing a critical word in the middle of the line and giving exactly nine phase strobes. It also does the same with a critical word of zero, where the wrap and the completion fall on the same phase. For wrapping writes it stops the burst one phase before the last line word and also sends extra phases after the disconnect, which shows that the address is held rather than wrapped.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BM_LINEAR = 2'd0,
    BM_WRAP   = 2'd1,
    BM_RESV   = 2'd2
  } burst_mode_e;
endpackage

// File: rtl/burst_code_decode.sv
module burst_code_decode
  import burst_pkg::*;
(
  input  logic [1:0]  code,
  output burst_mode_e mode
);
  always_comb begin
    unique case (code)
      2'b00:   mode = BM_LINEAR;
      2'b10:   mode = BM_WRAP;
      default: mode = BM_RESV;
    endcase
  end
endmodule

// File: rtl/burst_step_calc.sv
module burst_step_calc
  import burst_pkg::*;
#(
  parameter int WORD_W     = 30,
  parameter int LINE_WORDS = 8,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  burst_mode_e       mode,
  input  logic              is_write,
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  cnt,
  input  logic              done,
  output logic [WORD_W-1:0] word_nxt,
  output logic              advance,
  output logic              set_wrap,
  output logic              set_done,
  output logic              set_disc
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_inc;
  logic             at_last;
  logic             last_phase;

  assign idx        = word[IDX_W-1:0];
  assign idx_inc    = idx + IDX_W'(1);
  assign at_last    = (idx == {IDX_W{1'b1}});
  assign last_phase = (cnt == IDX_W'(LINE_WORDS - 1));

  always_comb begin
    word_nxt = word;
    advance  = 1'b0;
    set_wrap = 1'b0;
    set_done = 1'b0;
    set_disc = 1'b0;
    unique case (mode)
      BM_LINEAR: begin
        word_nxt = word + WORD_W'(1);
        advance  = 1'b1;
      end
      BM_WRAP: begin
        if (is_write) begin
          if (at_last) begin
            set_disc = 1'b1;
          end else begin
            word_nxt = {word[WORD_W-1:IDX_W], idx_inc};
            advance  = 1'b1;
          end
        end else if (done) begin
          set_disc = 1'b1;
        end else begin
          word_nxt = {word[WORD_W-1:IDX_W], idx_inc};
          advance  = 1'b1;
          set_wrap = at_last;
          set_done = last_phase;
        end
      end
      default: set_disc = 1'b1;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int WORD_W     = ADDR_W - 2,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int IDX_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              is_write,
  input  logic              phase_done,
  input  logic              xfer_end,
  output logic [WORD_W-1:0] word_addr,
  output logic              wrapped,
  output logic              line_done,
  output logic              disc_req
);
  burst_mode_e       mode_q, mode_d, mode_dec;
  logic [WORD_W-1:0] word_q, word_d, word_step;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic              active_q, active_d;
  logic              wrap_q, wrap_d;
  logic              done_q, done_d;
  logic              disc_q, disc_d;
  logic              step_en;
  logic              adv, s_wrap, s_done, s_disc;

  burst_code_decode u_dec (
    .code (addr_in[1:0]),
    .mode (mode_dec)
  );

  burst_step_calc #(
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_step (
    .mode     (mode_q),
    .is_write (wr_q),
    .word     (word_q),
    .cnt      (cnt_q),
    .done     (done_q),
    .word_nxt (word_step),
    .advance  (adv),
    .set_wrap (s_wrap),
    .set_done (s_done),
    .set_disc (s_disc)
  );

  assign step_en = active_q & phase_done & ~disc_q & ~xfer_end;

  always_comb begin
    mode_d   = mode_q;
    word_d   = word_q;
    cnt_d    = cnt_q;
    wr_d     = wr_q;
    active_d = active_q;
    wrap_d   = wrap_q;
    done_d   = done_q;
    disc_d   = disc_q;
    if (addr_valid) begin
      mode_d   = mode_dec;
      word_d   = addr_in[ADDR_W-1:2];
      cnt_d    = '0;
      wr_d     = is_write;
      active_d = 1'b1;
      wrap_d   = 1'b0;
      done_d   = 1'b0;
      disc_d   = (mode_dec == BM_RESV);
    end else if (xfer_end) begin
      active_d = 1'b0;
      disc_d   = 1'b0;
    end else if (step_en) begin
      if (adv) begin
        word_d = word_step;
        cnt_d  = cnt_q + IDX_W'(1);
      end
      wrap_d = wrap_q | s_wrap;
      done_d = done_q | s_done;
      disc_d = s_disc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= BM_LINEAR;
      word_q   <= '0;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      active_q <= 1'b0;
      wrap_q   <= 1'b0;
      done_q   <= 1'b0;
      disc_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      word_q   <= word_d;
      cnt_q    <= cnt_d;
      wr_q     <= wr_d;
      active_q <= active_d;
      wrap_q   <= wrap_d;
      done_q   <= done_d;
      disc_q   <= disc_d;
    end
  end

  assign word_addr = word_q;
  assign wrapped   = wrap_q;
  assign line_done = done_q;
  assign disc_req  = disc_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr_in,
  input logic              is_write,
  input logic              phase_done,
  input logic              xfer_end,
  input logic [WORD_W-1:0] word_addr,
  input logic              wrapped,
  input logic              line_done,
  input logic              disc_req,
  input burst_mode_e       mode_q,
  input logic              active_q,
  input logic              wr_q
);
  // R1 / R11: an address phase loads the word address regardless of phase_done
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (word_addr == $past(addr_in[ADDR_W-1:2])) && !wrapped && !line_done);

  // R2: linear order advances one word per accepted phase
  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && mode_q == BM_LINEAR && phase_done && !disc_req && !addr_valid && !xfer_end)
    |=> (word_addr == $past(word_addr) + WORD_W'(1)) && !disc_req);

  // R3: a wrapping read never leaves its line
  a_r3_stay_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && mode_q == BM_WRAP && !wr_q && !addr_valid)
    |=> word_addr[WORD_W-1:3] == $past(word_addr[WORD_W-1:3]));

  // R7: reserved codes are refused at once
  a_r7_reserved_disc: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (addr_in[1:0] == 2'b11 || addr_in[1:0] == 2'b01)) |=> disc_req);

  // R8: address frozen while a disconnect is pending
  a_r8_disc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_req && !addr_valid) |=> $stable(word_addr));

  // R9: end of transfer drops the disconnect request
  a_r9_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !addr_valid) |=> !disc_req);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .addr_in    (addr_in),
  .is_write   (is_write),
  .phase_done (phase_done),
  .xfer_end   (xfer_end),
  .word_addr  (word_addr),
  .wrapped    (wrapped),
  .line_done  (line_done),
  .disc_req   (disc_req),
  .mode_q     (mode_q),
  .active_q   (active_q),
  .wr_q       (wr_q)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_valid, is_write, phase_done, xfer_end;
  logic [31:0] addr_in;
  logic [29:0] word_addr;
  logic        wrapped, line_done, disc_req;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
    .is_write(is_write), .phase_done(phase_done), .xfer_end(xfer_end),
    .word_addr(word_addr), .wrapped(wrapped), .line_done(line_done),
    .disc_req(disc_req)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000_0000, 32'h0000_0FFC, 32'h0000_1016, 32'h0000_1016,
                                          32'h0000_1016, 32'h0000_1016, 32'h0000_1016, 32'h0000_1016,
                                          32'h0000_2003, 32'h0000_2001, 32'hFFFF_FFF8, 32'h0000_1002};
  localparam logic        V_WR   [NV] = '{0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
  localparam int          V_NPH  [NV] = '{3, 2, 3, 8, 9, 2, 3, 5, 0, 3, 3, 8};
  localparam logic [29:0] V_WORD [NV] = '{30'h0400_0003, 30'h401, 30'h400, 30'h405,
                                          30'h405, 30'h407, 30'h407, 30'h407,
                                          30'h800, 30'h800, 30'h1, 30'h400};
  localparam logic        V_WRAP [NV] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1};
  localparam logic        V_DONE [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 1};
  localparam logic        V_DISC [NV] = '{0, 0, 0, 0, 1, 0, 1, 1, 1, 1, 0, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic w);
    @(negedge clk);
    addr_valid = 1'b1; addr_in = a; is_write = w;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic phases(input int n);
    for (int i = 0; i < n; i++) begin
      phase_done = 1'b1;
      @(negedge clk);
    end
    phase_done = 1'b0;
  endtask

  task automatic end_xfer();
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; addr_valid = 1'b0; addr_in = '0; is_write = 1'b0;
    phase_done = 1'b0; xfer_end = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 word", {2'b0, word_addr}, 32'h0);
    chk("R10 flags", {29'b0, wrapped, line_done, disc_req}, 32'h0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      addr_phase(V_ADDR[v], V_WR[v]);
      phases(V_NPH[v]);
      chk($sformatf("R1-R8 vec%0d word", v), {2'b0, word_addr}, {2'b0, V_WORD[v]});
      chk($sformatf("R4 vec%0d wrapped", v), {31'b0, wrapped}, {31'b0, V_WRAP[v]});
      chk($sformatf("R5 vec%0d line_done", v), {31'b0, line_done}, {31'b0, V_DONE[v]});
      chk($sformatf("R6 R7 vec%0d disc", v), {31'b0, disc_req}, {31'b0, V_DISC[v]});
      end_xfer();
    end

    // R9: end clears disconnect, later phases ignored
    addr_phase(32'h0000_2003, 1'b0);
    chk("R7 disc after addr", {31'b0, disc_req}, 32'h1);
    end_xfer();
    chk("R9 disc cleared", {31'b0, disc_req}, 32'h0);
    phases(4);
    chk("R9 idle ignores phases", {2'b0, word_addr}, 32'h800);

    // R11: address phase beats a simultaneous data phase
    @(negedge clk);
    addr_valid = 1'b1; phase_done = 1'b1; addr_in = 32'h0000_4000; is_write = 1'b0;
    @(negedge clk);
    addr_valid = 1'b0; phase_done = 1'b0;
    chk("R11 load wins", {2'b0, word_addr}, 32'h1000);
    phases(1);
    chk("R2 step after load", {2'b0, word_addr}, 32'h1001);
    end_xfer();

    // R1: new address phase clears flags of a finished wrap read
    addr_phase(32'h0000_1016, 1'b0);
    phases(9);
    addr_phase(32'h0000_3000, 1'b0);
    chk("R1 flags cleared", {29'b0, wrapped, line_done, disc_req}, 32'h0);
    chk("R1 reload", {2'b0, word_addr}, 32'hC00);

    // R10: reset in the middle of a burst
    phases(2);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset word", {2'b0, word_addr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule